// File: doc/BRIEF.md
# Line-Duplicating Video Fetch Address Generator

This block produces the frame-buffer read address for a raster display. It takes the current pixel column and scanline from an external timing generator, together with the horizontal and vertical active flags, a frame base address and a duplication shift `n`. The address is formed as base plus the source row times the row pitch plus the column. The source row is the scanline with its low `n` bits dropped, so each stored row is shown on 2^n consecutive scanlines. No address counter is ever re-latched.

The output register always holds the address of the pixel that will be shown next. The memory read therefore runs one pixel ahead of the screen. On the last active pixel of a scanline the block picks the next line's first fetch. It fetches the start of the same source row again unless the low `n` bits of the scanline are all ones. In that case it moves to the start of the next source row. On the last pixel of the last active line it loads the base address, so the first pixel of the next frame is ready before that frame begins. Outside the active area, and whenever the pixel enable is low, the address holds.

Top module: `linedup_fetch_addr`

## Requirements
- R1: While `rst` is high, `rd_addr` becomes 0 at the next clock edge.
- R2: On a clock edge with `pix_en`, `h_act` and `v_act` high and `x_pos` not equal to `H_PIX-1`, `rd_addr` becomes `base_addr + (y_pos >> n) * ROW_BYTES + x_pos + 1`.
- R3: On the last active pixel (`x_pos == H_PIX-1`) of a line other than `V_LINES-1` whose low `n` bits are not all ones, `rd_addr` becomes `base_addr + (y_pos >> n) * ROW_BYTES`. The same source row is fetched again.
- R4: On the last active pixel of a line other than `V_LINES-1` whose low `n` bits are all ones, `rd_addr` becomes `base_addr + ((y_pos >> n) + 1) * ROW_BYTES`.
- R5: On the last active pixel of line `V_LINES-1`, `rd_addr` becomes `base_addr`.
- R6: A clock edge with `pix_en` low leaves `rd_addr` unchanged.
- R7: A clock edge with `pix_en` high and either `h_act` or `v_act` low leaves `rd_addr` unchanged.
- R8: With `n = 0`, every line advances to the next source row at its end. With `n = 1` and `n = 2`, each source row covers 2 and 4 scanlines respectively.
- R9: All address arithmetic wraps modulo 2^`ADDR_W`.
- R10: A `dup_shift` value above `MAX_SHIFT` acts as `MAX_SHIFT`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel clock enable, one per displayed pixel |
| x_pos | input | X_W | Current pixel column from the timing generator |
| y_pos | input | Y_W | Current scanline from the timing generator |
| h_act | input | 1 | Column lies in the active area |
| v_act | input | 1 | Scanline lies in the active area |
| base_addr | input | ADDR_W | Address of the first pixel of the frame |
| dup_shift | input | SH_W | Duplication shift n; each row is shown on 2^n lines |
| rd_addr | output | ADDR_W | Registered look-ahead read address |

## Verification
The assertions assume that the timing generator is well behaved. The flags are high only while `x_pos < H_PIX` and `y_pos < V_LINES`. The counters step only on cycles with `pix_en` high. `base_addr` and `dup_shift` stay fixed within a frame. The bench drives complete small frames with horizontal and vertical blanking, built by a counter model that obeys these rules. It changes the base and the shift only between frames, and it inserts stall cycles by lowering `pix_en` with the counters frozen. Each expected address comes from a model that follows the requirement text, applied to the same input stream.

// File: rtl/linedup_pkg.sv
package linedup_pkg;

  // Kind of fetch chosen for the current pixel-enable cycle
  typedef enum logic [2:0] {
    FK_HOLD      = 3'd0,
    FK_STEP      = 3'd1,
    FK_ROW_AGAIN = 3'd2,
    FK_ROW_NEXT  = 3'd3,
    FK_FRAME     = 3'd4
  } fetch_kind_e;

  function automatic int unsigned shift_width(input int unsigned max_shift);
    return (max_shift < 1) ? 1 : $clog2(max_shift + 1);
  endfunction

endpackage

// File: rtl/linedup_row_split.sv
module linedup_row_split #(
  parameter int Y_W       = 10,
  parameter int MAX_SHIFT = 2,
  parameter int SH_W      = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [Y_W-1:0]  y_pos,
  input  logic [SH_W-1:0] dup_shift,
  output logic [Y_W-1:0]  src_row,
  output logic            last_dup
);

  logic [Y_W-1:0]  row_opt  [0:MAX_SHIFT];
  logic            ones_opt [0:MAX_SHIFT];
  logic [SH_W-1:0] eff_shift;

  // one candidate per supported shift; the mux picks the live one
  for (genvar s = 0; s <= MAX_SHIFT; s++) begin : g_shift
    assign row_opt[s] = y_pos >> s;
    if (s == 0) begin : g_none
      assign ones_opt[s] = 1'b1;
    end else begin : g_some
      assign ones_opt[s] = &y_pos[s-1:0];
    end
  end

  always_comb begin
    if (dup_shift > SH_W'(MAX_SHIFT)) eff_shift = SH_W'(MAX_SHIFT);
    else                              eff_shift = dup_shift;
  end

  assign src_row  = row_opt[eff_shift];
  assign last_dup = ones_opt[eff_shift];

  // R8: with no duplication every line is the last copy of its row
  p_nodup_last_r8: assert property (@(posedge clk) disable iff (rst)
    (dup_shift == '0) |-> (last_dup && src_row == y_pos));

  // R10: an over-range shift behaves as the largest legal shift
  p_clamp_r10: assert property (@(posedge clk) disable iff (rst)
    (dup_shift > SH_W'(MAX_SHIFT)) |-> (src_row == (y_pos >> MAX_SHIFT)));

endmodule

// File: rtl/linedup_const_mult.sv
module linedup_const_mult #(
  parameter int IN_W      = 10,
  parameter int OUT_W     = 16,
  parameter int FACTOR    = 320
) (
  input  logic [IN_W-1:0]  in_val,
  output logic [OUT_W-1:0] product
);

  localparam int F_W = (FACTOR < 2) ? 1 : $clog2(FACTOR + 1);

  logic [OUT_W-1:0] acc [0:F_W];

  assign acc[0] = '0;

  // shift-and-add over the set bits of the constant pitch
  for (genvar b = 0; b < F_W; b++) begin : g_bit
    if (((FACTOR >> b) & 1) == 1) begin : g_add
      assign acc[b+1] = acc[b] + (OUT_W'(in_val) << b);
    end else begin : g_skip
      assign acc[b+1] = acc[b];
    end
  end

  assign product = acc[F_W];

endmodule

// File: rtl/linedup_fetch_sel.sv
module linedup_fetch_sel
  import linedup_pkg::*;
#(
  parameter int X_W     = 10,
  parameter int Y_W     = 10,
  parameter int H_PIX   = 640,
  parameter int V_LINES = 480
) (
  input  logic        pix_en,
  input  logic        h_act,
  input  logic        v_act,
  input  logic [X_W-1:0] x_pos,
  input  logic [Y_W-1:0] y_pos,
  input  logic        last_dup,
  output fetch_kind_e kind
);

  localparam logic [X_W-1:0] X_LAST = X_W'(H_PIX - 1);
  localparam logic [Y_W-1:0] Y_LAST = Y_W'(V_LINES - 1);

  logic active, line_end, frame_end;

  assign active    = pix_en && h_act && v_act;
  assign line_end  = (x_pos == X_LAST);
  assign frame_end = (y_pos == Y_LAST);

  always_comb begin
    kind = FK_HOLD;
    if (active) begin
      if (!line_end)     kind = FK_STEP;
      else if (frame_end) kind = FK_FRAME;
      else if (last_dup)  kind = FK_ROW_NEXT;
      else                kind = FK_ROW_AGAIN;
    end
  end

endmodule

// File: rtl/linedup_fetch_addr.sv
module linedup_fetch_addr
  import linedup_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int X_W       = 10,
  parameter int Y_W       = 10,
  parameter int H_PIX     = 640,
  parameter int V_LINES   = 480,
  parameter int ROW_BYTES = 320,
  parameter int MAX_SHIFT = 2,
  parameter int SH_W      = shift_width(MAX_SHIFT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic [X_W-1:0]    x_pos,
  input  logic [Y_W-1:0]    y_pos,
  input  logic              h_act,
  input  logic              v_act,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [SH_W-1:0]   dup_shift,
  output logic [ADDR_W-1:0] rd_addr
);

  localparam logic [X_W-1:0]    X_LAST = X_W'(H_PIX - 1);
  localparam logic [Y_W-1:0]    Y_LAST = Y_W'(V_LINES - 1);
  localparam logic [ADDR_W-1:0] PITCH  = ADDR_W'(ROW_BYTES);

  logic [Y_W-1:0]    src_row;
  logic              last_dup;
  logic [ADDR_W-1:0] row_off;
  logic [ADDR_W-1:0] row_start;
  fetch_kind_e       kind;
  logic [ADDR_W-1:0] next_addr;

  linedup_row_split #(
    .Y_W(Y_W), .MAX_SHIFT(MAX_SHIFT), .SH_W(SH_W)
  ) u_row_split (
    .clk(clk), .rst(rst), .y_pos(y_pos), .dup_shift(dup_shift),
    .src_row(src_row), .last_dup(last_dup)
  );

  linedup_const_mult #(
    .IN_W(Y_W), .OUT_W(ADDR_W), .FACTOR(ROW_BYTES)
  ) u_pitch_mult (
    .in_val(src_row), .product(row_off)
  );

  linedup_fetch_sel #(
    .X_W(X_W), .Y_W(Y_W), .H_PIX(H_PIX), .V_LINES(V_LINES)
  ) u_fetch_sel (
    .pix_en(pix_en), .h_act(h_act), .v_act(v_act),
    .x_pos(x_pos), .y_pos(y_pos), .last_dup(last_dup), .kind(kind)
  );

  assign row_start = base_addr + row_off;

  always_comb begin
    unique case (kind)
      FK_STEP:      next_addr = row_start + ADDR_W'(x_pos) + ADDR_W'(1);
      FK_ROW_AGAIN: next_addr = row_start;
      FK_ROW_NEXT:  next_addr = row_start + PITCH;
      FK_FRAME:     next_addr = base_addr;
      default:      next_addr = rd_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_addr <= '0;
    else     rd_addr <= next_addr;
  end

  // R6: no pixel enable, no movement
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> $stable(rd_addr));

  // R7: blanking keeps the look-ahead address parked
  p_hold_blank_r7: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !(h_act && v_act)) |=> $stable(rd_addr));

  // R5: last pixel of the frame reloads the base
  p_frame_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (pix_en && h_act && v_act && x_pos == X_LAST && y_pos == Y_LAST)
      |=> rd_addr == $past(base_addr));

  // R3: a non-final copy of a row fetches its own row start again
  p_row_again_r3: assert property (@(posedge clk) disable iff (rst)
    (pix_en && h_act && v_act && x_pos == X_LAST && y_pos != Y_LAST && !last_dup)
      |=> rd_addr == $past(base_addr + row_off));

endmodule

// File: tb/linedup_fetch_addr_bench.sv
module linedup_fetch_addr_bench;

  localparam int AW = 16, XW = 5, YW = 5;
  localparam int HP = 8, HT = 11, VL = 8, VT = 10, RB = 5, MS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b0, h_act = 1'b0, v_act = 1'b0;
  logic [XW-1:0] x_pos = '0;
  logic [YW-1:0] y_pos = '0;
  logic [AW-1:0] base_addr = '0;
  logic [1:0]    dup_shift = '0;
  logic [AW-1:0] rd_addr;

  int tests = 0, fails = 0;
  logic [AW-1:0] exp_q [$];
  string         tag_q [$];
  logic [AW-1:0] m_addr = '0;

  always #5 clk = ~clk;

  linedup_fetch_addr #(
    .ADDR_W(AW), .X_W(XW), .Y_W(YW), .H_PIX(HP), .V_LINES(VL),
    .ROW_BYTES(RB), .MAX_SHIFT(MS)
  ) u_linedup_fetch_addr (
    .clk(clk), .rst(rst), .pix_en(pix_en), .x_pos(x_pos), .y_pos(y_pos),
    .h_act(h_act), .v_act(v_act), .base_addr(base_addr),
    .dup_shift(dup_shift), .rd_addr(rd_addr)
  );

  // expected next address, written from the requirement text
  task automatic model_step(input int x, input int y, input bit pe,
                            input int base, input int sh,
                            output logic [AW-1:0] nxt, output string tag);
    int n, row, full;
    bit ones;
    n    = (sh > MS) ? MS : sh;
    row  = y >> n;
    ones = ((y & ((1 << n) - 1)) == ((1 << n) - 1));
    full = int'(m_addr);
    if (!pe) tag = "R6";
    else if (!(x < HP && y < VL)) tag = "R7";
    else if (x != HP - 1) begin full = base + row * RB + x + 1; tag = "R2"; end
    else if (y == VL - 1) begin full = base; tag = "R5"; end
    else if (ones) begin full = base + (row + 1) * RB; tag = (n == 0) ? "R8" : "R4"; end
    else begin full = base + row * RB; tag = "R3"; end
    if (full > 65535) tag = {tag, "/R9"};
    if (sh > MS && pe && x < HP && y < VL) tag = {tag, "/R10"};
    nxt = AW'(full);
  endtask

  task automatic run_frame(input int base, input int sh, input bit stalls);
    int cyc = 0;
    logic [AW-1:0] e;
    string t;
    for (int y = 0; y < VT; y++) begin
      for (int x = 0; x < HT; x++) begin
        bit go = 1'b0;
        while (!go) begin
          @(negedge clk);
          pix_en    = !(stalls && (cyc % 3 == 2));
          go        = pix_en;
          x_pos     = XW'(x);
          y_pos     = YW'(y);
          h_act     = (x < HP);
          v_act     = (y < VL);
          base_addr = AW'(base);
          dup_shift = 2'(sh);
          model_step(x, y, pix_en, base, sh, e, t);
          m_addr = e;
          exp_q.push_back(e);
          tag_q.push_back(t);
          cyc++;
        end
      end
    end
  endtask

  // monitor: compare one expected item per clock, just after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [AW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (rd_addr !== e) begin
        fails++;
        $display("FAIL %s: rd_addr=%h expected=%h", t, rd_addr, e);
      end
    end
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;   // R1 reset value
    if (rd_addr !== '0) begin
      fails++;
      $display("FAIL R1: rd_addr=%h expected=0000", rd_addr);
    end
    rst = 1'b0;
    run_frame(16'h0100, 0, 1'b0);   // R8 no duplication
    run_frame(16'h0200, 1, 1'b1);   // R3 R4 with stalls for R6
    run_frame(16'hFFF0, 2, 1'b0);   // R9 wrap, four lines per row
    run_frame(16'h0040, 3, 1'b1);   // R10 clamp
    run_frame(16'h0300, 1, 1'b0);   // R5 base change between frames
    @(negedge clk);
    pix_en = 1'b0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule